// File: doc/BRIEF.md
# I2C byte buffer and status flags

This block sits between a CPU register port and a separate I2C shift engine. It holds one received byte and one byte waiting to be sent. Both sit behind a single data address: a read returns the received byte and a write loads the outgoing byte. It keeps the receive-full, transmit-empty, overrun and bus-busy flags, and it raises receive and transmit interrupt requests when they are enabled.

The shift engine reports bus events to the block as one-cycle strobes:
- an SCL falling edge, together with the number of the bit that has just completed;
- the moment the pending byte is taken for sending;
- start and stop conditions.

The block also samples the SCL and SDA line levels. It owns a small output shifter that presents the outgoing byte one bit at a time, MSB first. It also flags whether the current byte is the first one after a start, whose LSB carries the transfer direction.

Register map on the 2-bit address:
- Address 0 is the data register.
- Address 1 is status/control. Bit 0 is receive-full (read only). Bit 1 is transmit-empty (read only). Bit 2 is overrun (read only). Bit 3 is bus-busy (read only). Bit 4 is the receive interrupt enable. Bit 5 is the transmit interrupt enable. Bit 6 is the DMA-mode bit. Bit 7 is the error-clear control, which always reads 1.
- Address 2 bit 0 is the interface enable.
- Unused bits read 0.

Top module: `i2c_bytebuf_status`

## Requirements
- R1: After reset, the status reads with transmit-empty = 1 and receive-full, overrun, bus-busy and all enables = 0. Bit 7 reads 1, so status reads 0x82. The received byte reads 0x00. A transmit load with no write since reset presents all ones on `tx_bit`.
- R2: Address 0 is shared. A read returns the received byte, and a write loads the outgoing byte without changing what a read returns.
- R3: A strobe on `eng_scl_fall` with `eng_bit_cnt` = 8 stores `eng_rx_data` and sets receive-full, whatever the acknowledge later is. SCL falls with any other count store nothing.
- R4: A read of address 0 clears receive-full. If a new byte completes in the same cycle, the flag stays 1 and the new byte is stored.
- R5: A write to address 0 clears transmit-empty. An `eng_tx_load` strobe sets it again. If both happen in the same cycle, the write wins.
- R6: `irq_rx` is 1 exactly while status bit 4 and receive-full are both 1. `irq_tx` is 1 exactly while status bit 5 and transmit-empty are both 1.
- R7: A byte that completes while receive-full is already 1 (and no read of address 0 happens in that cycle) sets overrun and leaves the stored byte unchanged.
- R8: Writing status with bit 7 = 1 clears overrun. Writing bit 7 = 0 leaves it set. Bit 7 always reads back as 1.
- R9: On `eng_tx_load`, the pending byte moves to the output shifter and `tx_bit` shows its bit 7. Each later SCL fall shifts the next lower bit out.
- R10: `addr_phase` goes to 1 on `eng_start`. It returns to 0 at the SCL fall that completes bit 8.
- R11: Status bit 6 (DMA mode) takes a written value only while the enable bit (address 2 bit 0) is 0. Writes to it at other times are ignored.
- R12: Bus-busy becomes 1 when `scl_in` or `sda_in` is seen LOW. It returns to 0 on `eng_stop`, and stop takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_addr | input | 2 | register address |
| reg_wr | input | 1 | write strobe |
| reg_rd | input | 1 | read strobe (side effects only) |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data, combinational on the address |
| eng_scl_fall | input | 1 | SCL falling-edge strobe from the shift engine |
| eng_bit_cnt | input | 4 | number of the bit just completed (1..8) |
| eng_rx_data | input | 8 | received byte, valid with the bit-8 fall |
| eng_tx_load | input | 1 | pending byte taken for sending |
| eng_start | input | 1 | start condition seen |
| eng_stop | input | 1 | stop condition seen |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| tx_bit | output | 1 | current outgoing bit, MSB first |
| addr_phase | output | 1 | first byte after start in progress |
| irq_rx | output | 1 | receive interrupt request |
| irq_tx | output | 1 | transmit interrupt request |

## Verification
The bench goes after four corner cases.
- A byte that completes while the previous one is unread. A design that overwrote the stored byte there, or missed the overrun, would return the wrong data on the next read.
- Status written back unchanged after a read. Bit 7 reads 1, so this must clear overrun, while an explicit 0 in bit 7 must not. A design that got this backwards would keep a stale overrun or lose a real one.
- A DMA-mode write while the interface is enabled, which a faulty design would accept.
- A stop arriving together with a LOW line, which must leave the bus idle.

Random mixes of received bytes, reads, status writes, data writes and transmit loads are checked against a flag model kept in the bench.

// File: rtl/i2c_bytebuf_status.sv
module i2c_bytebuf_status #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              eng_scl_fall,
  input  logic [CNT_W-1:0]  eng_bit_cnt,
  input  logic [BYTE_W-1:0] eng_rx_data,
  input  logic              eng_tx_load,
  input  logic              eng_start,
  input  logic              eng_stop,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              tx_bit,
  output logic              addr_phase,
  output logic              irq_rx,
  output logic              irq_tx
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_CTRL = 2'd2;

  logic [BYTE_W-1:0] rx_q, tx_q, sh_q;
  logic rx_full, tx_empty, ovr, busy, rx_ie, tx_ie, dma, en_q, aph_q;

  wire byte_done = eng_scl_fall && (eng_bit_cnt == LAST_BIT);
  wire rd_data   = reg_rd && reg_addr == A_DATA;
  wire wr_data   = reg_wr && reg_addr == A_DATA;
  wire wr_stat   = reg_wr && reg_addr == A_STAT;
  wire wr_ctrl   = reg_wr && reg_addr == A_CTRL;
  wire ovr_set   = byte_done && rx_full && !rd_data;
  wire rx_take   = byte_done && !ovr_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
      rx_full <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (rx_take) rx_q <= eng_rx_data;
      if (rx_take) rx_full <= 1'b1;
      else if (rd_data) rx_full <= 1'b0;
      if (ovr_set) ovr <= 1'b1;
      else if (wr_stat && reg_wdata[7]) ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '1;
      sh_q <= '1;
      tx_empty <= 1'b1;
    end else begin
      if (wr_data) tx_q <= reg_wdata;
      if (wr_data) tx_empty <= 1'b0;
      else if (eng_tx_load) tx_empty <= 1'b1;
      if (eng_tx_load) sh_q <= tx_q;
      else if (eng_scl_fall) sh_q <= {sh_q[BYTE_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ie <= 1'b0;
      tx_ie <= 1'b0;
      dma <= 1'b0;
      en_q <= 1'b0;
      busy <= 1'b0;
      aph_q <= 1'b0;
    end else begin
      if (wr_stat) begin
        rx_ie <= reg_wdata[4];
        tx_ie <= reg_wdata[5];
        if (!en_q) dma <= reg_wdata[6];
      end
      if (wr_ctrl) en_q <= reg_wdata[0];
      if (eng_stop) busy <= 1'b0;
      else if (!scl_in || !sda_in) busy <= 1'b1;
      if (eng_start) aph_q <= 1'b1;
      else if (byte_done) aph_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DATA: reg_rdata = rx_q;
      A_STAT: reg_rdata = {1'b1, dma, tx_ie, rx_ie, busy, ovr, tx_empty, rx_full};
      A_CTRL: reg_rdata[0] = en_q;
      default: reg_rdata = '0;
    endcase
  end

  assign tx_bit     = sh_q[BYTE_W-1];
  assign addr_phase = aph_q;
  assign irq_rx     = rx_ie & rx_full;
  assign irq_tx     = tx_ie & tx_empty;

  assert_rx_full_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> rx_full);
  assert_rd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !byte_done) |=> !rx_full);
  assert_tx_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !tx_empty);
  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> (ovr && $stable(rx_q)));
  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[7] && !ovr_set) |=> !ovr);
  assert_dma_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(dma));
  assert_stop_idles_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stop |=> !busy);
  assert_shift_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_load |=> (tx_bit == $past(tx_q[BYTE_W-1])));
endmodule

// File: tb/i2c_bytebuf_status_test.sv
module i2c_bytebuf_status_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic eng_scl_fall = 0, eng_tx_load = 0, eng_start = 0, eng_stop = 0;
  logic [3:0] eng_bit_cnt = 0;
  logic [7:0] eng_rx_data = 0;
  logic scl_in = 1, sda_in = 1;
  logic tx_bit, addr_phase, irq_rx, irq_tx;

  int checks = 0, fails = 0;
  logic m_full, m_te, m_ovr;
  logic [7:0] m_rx;

  i2c_bytebuf_status uut (.*);

  always #(CLK_NS/2) clk = ~clk;

  initial begin
    #(CLK_NS*100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [7:0] exp_stat(logic full, logic te, logic ov);
    return {4'b1000, 1'b0, ov, te, full};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    reg_wr = 0; reg_rd = 0; eng_scl_fall = 0; eng_tx_load = 0;
    eng_start = 0; eng_stop = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1; #1 d = reg_rdata; step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; step();
  endtask

  task automatic rxb(input logic [7:0] d);
    eng_scl_fall = 1; eng_bit_cnt = 8; eng_rx_data = d; step();
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    #(CLK_NS*2 + 1); rst_n = 1; #(CLK_NS);
    @(negedge clk);

    rd(1, d); chk("R1 status", d, 8'h82);
    rd(0, d); chk("R1 rx byte", d, 8'h00);
    chk("R6 irq idle", {irq_rx, irq_tx}, 0);
    eng_tx_load = 1; step(); chk("R1 tx resets ones", tx_bit, 1);

    wr(0, 8'hA5); rd(1, d); chk("R5 write clears empty", d[1], 0);
    rd(0, d); chk("R2 write leaves rx", d, 8'h00);
    eng_tx_load = 1; step(); rd(1, d); chk("R5 load sets empty", d[1], 1);
    for (int i = 7; i >= 0; i--) begin
      chk("R9 msb first", tx_bit, (8'hA5 >> i) & 1);
      eng_scl_fall = 1; eng_bit_cnt = 4'(8 - i); if (i == 0) eng_bit_cnt = 1; step();
    end

    eng_scl_fall = 1; eng_bit_cnt = 5; eng_rx_data = 8'h3C; step();
    rd(1, d); chk("R3 other count no store", d[0], 0);
    rxb(8'h3C); rd(1, d); chk("R3 full set", d[0], 1);
    wr(1, 8'h30); chk("R6 irq_rx", irq_rx, 1); chk("R6 irq_tx", irq_tx, 1);
    rxb(8'h99); rd(1, d); chk("R7 overrun", d[2], 1);
    wr(1, 8'h00); rd(1, d); chk("R8 zero keeps ovr", d[2], 1);
    chk("R8 bit7 reads one", d[7], 1);
    chk("R6 irq off", irq_rx, 0);
    rd(0, d); chk("R7 byte kept", d, 8'h3C);
    rd(1, d); chk("R4 read clears", d[0], 0);
    wr(1, d); rd(1, d); chk("R8 rmw clears ovr", d[2], 0);

    rxb(8'h11);
    reg_addr = 0; reg_rd = 1; eng_scl_fall = 1; eng_bit_cnt = 8; eng_rx_data = 8'h22; step();
    rd(1, d); chk("R4 same-cycle full", d[2:0], 3'b011);
    rd(0, d); chk("R4 same-cycle data", d, 8'h22);

    wr(0, 8'h5A); reg_addr = 0; reg_wdata = 8'h66; reg_wr = 1; eng_tx_load = 1; step();
    rd(1, d); chk("R5 write wins", d[1], 0);

    wr(1, 8'h40); wr(2, 8'h01); wr(1, 8'h00); rd(1, d); chk("R11 dma locked", d[6], 1);
    wr(2, 8'h00); wr(1, 8'h00); rd(1, d); chk("R11 dma free", d[6], 0);

    sda_in = 0; eng_start = 1; step(); sda_in = 1;
    rd(1, d); chk("R12 busy", d[3], 1); chk("R10 addr phase", addr_phase, 1);
    rxb(8'h00); chk("R10 addr phase ends", addr_phase, 0);
    rd(0, d);
    scl_in = 0; eng_stop = 1; step(); scl_in = 1;
    rd(1, d); chk("R12 stop wins", d[3], 0);

    m_full = 0; m_te = 0; m_ovr = 0; m_rx = 8'h00;
    rd(1, d); m_te = d[1];
    for (int n = 0; n < 300; n++) begin
      int op;
      logic [7:0] v;
      op = $urandom % 5; v = 8'($urandom);
      case (op)
        0: begin rxb(v); if (m_full) m_ovr = 1; else begin m_rx = v; m_full = 1; end end
        1: begin rd(0, d); chk("R2 random read", d, m_rx); m_full = 0; end
        2: begin wr(1, {v[7], 7'h0}); if (v[7]) m_ovr = 0; end
        3: begin wr(0, v); m_te = 0; end
        default: begin eng_tx_load = 1; step(); m_te = 1; end
      endcase
      rd(1, d); chk("R7 random status", d, exp_stat(m_full, m_te, m_ovr));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule